// File: doc/BRIEF.md
# Flat Panel Power Sequencer

This block brings an LCD panel up and down by switching five enables in a fixed order: the display-period enable, the logic supply, the pixel data path, the bias supply and the backlight. Two delay profiles are available. The standard profile uses all five enables. The legacy profile never raises display-period and switches the bias supply and the backlight together. In both profiles the power-down order is the reverse of the power-up order.

Delays are counted in pulses of a millisecond tick. Every delay is a parameter, so an instance can be built with short delays. A two-bit request code selects the target. One code means "on". The three other codes (standby, suspend, off) all mean "power down". The pad drive code changes only after a sequence has completed. If the request reverses partway through a sequence, the step in progress is allowed to complete. The block then works back from the rail state it has reached, one step at a time.

Top module: `panel_power_seq`

## Requirements
- R1: While reset is asserted, all five enables are 0, pad_drive is 2'b00, busy is 0 and done is 1.
- R2: Standard profile power-up (legacy_sel=0 when leaving fully off). One cycle after the request is accepted, disp_en rises. After that, vdd_en, data_en, vee_en and bl_en rise in that order, with waits of STD_T_VDD, STD_T_DATA, STD_T_VEE and STD_T_BL ticks before each. With ms_tick held high, a wait of d ticks places a step d+1 cycles after the previous step.
- R3: Standard profile power-down. bl_en falls one cycle after acceptance. Then vee_en falls after STD_T_BL ticks, data_en after STD_T_VEE ticks and vdd_en after STD_T_DATA ticks. disp_en falls one cycle after vdd_en.
- R4: Legacy profile power-up. vdd_en rises after LEG_T_VDD ticks and data_en after LEG_T_DATA more ticks. After LEG_T_VEE more ticks, vee_en and bl_en rise on the same edge. disp_en stays 0 throughout.
- R5: Legacy profile power-down. After LEG_T_VEE ticks, vee_en and bl_en fall together. data_en falls after LEG_T_DATA more ticks and vdd_en after LEG_T_VDD more ticks.
- R6: Request encoding. req_mode 2'b00 requests power-up. 2'b01, 2'b10 and 2'b11 all request power-down. Holding 2'b00 while fully on starts nothing.
- R7: pad_drive becomes 2'b11 one cycle after a power-up completes and 2'b00 one cycle after a power-down completes. It is unchanged on the completion edge itself.
- R8: A step with a zero-tick wait still takes one cycle. Its two neighbouring enables change on consecutive, distinct edges.
- R9: Waits advance only on ms_tick pulses. With ms_tick low, a pending non-zero wait never completes, and busy stays high.
- R10: If the request reverses mid-sequence, the step being waited on completes first. The opposite sequence then starts from the rail state reached, with no step skipped.
- R11: busy rises on the edge that accepts a request and falls on the edge of that sequence's last enable change. done is a one-cycle pulse on that same edge.
- R12: legacy_sel is sampled only when a power-up starts from fully off. Changing it at any other time has no effect on the running or the next power-down sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mode | input | 2 | Power request: 2'b00 on, any other value power down |
| legacy_sel | input | 1 | Profile select: 0 standard, 1 legacy |
| ms_tick | input | 1 | One-cycle millisecond pulse that advances the waits |
| disp_en | output | 1 | Display-period enable |
| vdd_en | output | 1 | Logic supply enable |
| data_en | output | 1 | Pixel data path enable |
| vee_en | output | 1 | Bias supply enable |
| bl_en | output | 1 | Backlight enable |
| pad_drive | output | 2 | I/O pad drive code: 2'b11 powered on, 2'b00 off |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Pulses for one cycle when a sequence completes |

## Verification
The internal rail level and the latched profile set all five enables. A wrong level therefore shows on the enables at the next edge as an ordering break, such as data_en high while vdd_en is low, or as a step arriving too early or too late against the tick count. A lost direction bit after a reversal shows within one step, as an enable moving the wrong way or a skipped step. A wrong profile latch shows on the first step, because disp_en either rises or stays low.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic {PROF_STD = 1'b0, PROF_LEG = 1'b1} prof_e;
  typedef enum logic {DIR_DN = 1'b0, DIR_UP = 1'b1} dir_e;

  localparam lvl_t STD_TOP = 3'd5;
  localparam lvl_t LEG_TOP = 3'd3;
  localparam logic [1:0] REQ_ON  = 2'b00;
  localparam logic [1:0] PAD_ON  = 2'b11;
  localparam logic [1:0] PAD_OFF = 2'b00;

  typedef struct packed {
    logic bl;
    logic vee;
    logic data;
    logic vdd;
    logic disp;
  } rails_t;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic lvl_t top_level(prof_e p);
    return (p == PROF_LEG) ? LEG_TOP : STD_TOP;
  endfunction

  // Rail level -> enable pattern; each profile stacks its rails in order.
  function automatic rails_t rails_for(prof_e p, lvl_t l);
    rails_t r;
    if (p == PROF_STD) begin
      r.disp = (l >= 3'd1);
      r.vdd  = (l >= 3'd2);
      r.data = (l >= 3'd3);
      r.vee  = (l >= 3'd4);
      r.bl   = (l >= 3'd5);
    end else begin
      r.disp = 1'b0;
      r.vdd  = (l >= 3'd1);
      r.data = (l >= 3'd2);
      r.vee  = (l >= 3'd3);
      r.bl   = (l >= 3'd3);
    end
    return r;
  endfunction
endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear)             cnt_q <= '0;
    else if (tick && !expired)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pps_rail_map.sv
module pps_rail_map
  import pps_pkg::*;
(
  input  prof_e  prof,
  input  lvl_t   lvl,
  output rails_t rails
);
  assign rails = rails_for(prof, lvl);
endmodule

// File: rtl/pps_step_ctrl.sv
module pps_step_ctrl
  import pps_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int STD_T_VDD  = 200,
  parameter int STD_T_DATA = 25,
  parameter int STD_T_VEE  = 0,
  parameter int STD_T_BL   = 25,
  parameter int LEG_T_VDD  = 25,
  parameter int LEG_T_DATA = 510,
  parameter int LEG_T_VEE  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want_on,
  input  logic             prof_sel,
  input  logic             expired,
  output lvl_t             lvl_q,
  output prof_e            prof_q,
  output logic             active_q,
  output logic             done_q,
  output logic [1:0]       pad_q,
  output logic             step_fire,
  output logic             timer_clr,
  output logic [CNT_W-1:0] limit
);
  dir_e  dir_q;
  prof_e prof_eff;
  lvl_t  lvl_nx;
  logic  start_up, start_dn, at_end;

  // Wait (in ticks) before the next step from level l in direction d.
  function automatic logic [CNT_W-1:0] step_delay(prof_e p, dir_e d, lvl_t l);
    int v;
    v = 0;
    if (p == PROF_STD) begin
      if (d == DIR_UP) begin
        case (l)
          3'd1:    v = STD_T_VDD;
          3'd2:    v = STD_T_DATA;
          3'd3:    v = STD_T_VEE;
          3'd4:    v = STD_T_BL;
          default: v = 0;
        endcase
      end else begin
        case (l)
          3'd4:    v = STD_T_BL;
          3'd3:    v = STD_T_VEE;
          3'd2:    v = STD_T_DATA;
          default: v = 0;
        endcase
      end
    end else begin
      if (d == DIR_UP) begin
        case (l)
          3'd0:    v = LEG_T_VDD;
          3'd1:    v = LEG_T_DATA;
          3'd2:    v = LEG_T_VEE;
          default: v = 0;
        endcase
      end else begin
        case (l)
          3'd3:    v = LEG_T_VEE;
          3'd2:    v = LEG_T_DATA;
          3'd1:    v = LEG_T_VDD;
          default: v = 0;
        endcase
      end
    end
    return v[CNT_W-1:0];
  endfunction

  assign prof_eff  = (lvl_q == '0) ? prof_e'(prof_sel) : prof_q;
  assign start_up  = !active_q && want_on && (lvl_q < top_level(prof_eff));
  assign start_dn  = !active_q && !want_on && (lvl_q != '0);
  assign step_fire = active_q && expired;
  assign lvl_nx    = (dir_q == DIR_UP) ? lvl_q + 3'd1 : lvl_q - 3'd1;
  assign at_end    = (dir_q == DIR_UP) ? (lvl_nx == top_level(prof_q)) : (lvl_nx == '0);
  assign timer_clr = !active_q || step_fire;
  assign limit     = step_delay(prof_q, dir_q, lvl_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      dir_q    <= DIR_DN;
      lvl_q    <= '0;
      prof_q   <= PROF_STD;
      done_q   <= 1'b1;
      pad_q    <= PAD_OFF;
    end else begin
      done_q <= 1'b0;
      if (done_q) pad_q <= (dir_q == DIR_UP) ? PAD_ON : PAD_OFF;
      if (start_up) begin
        active_q <= 1'b1;
        dir_q    <= DIR_UP;
        prof_q   <= prof_eff;
      end else if (start_dn) begin
        active_q <= 1'b1;
        dir_q    <= DIR_DN;
      end else if (step_fire) begin
        lvl_q <= lvl_nx;
        if (at_end) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else if ((want_on ? DIR_UP : DIR_DN) != dir_q) begin
          dir_q <= want_on ? DIR_UP : DIR_DN;
        end
      end
    end
  end
endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import pps_pkg::*;
#(
  parameter int STD_T_VDD  = 200,
  parameter int STD_T_DATA = 25,
  parameter int STD_T_VEE  = 0,
  parameter int STD_T_BL   = 25,
  parameter int LEG_T_VDD  = 25,
  parameter int LEG_T_DATA = 510,
  parameter int LEG_T_VEE  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_mode,
  input  logic       legacy_sel,
  input  logic       ms_tick,
  output logic       disp_en,
  output logic       vdd_en,
  output logic       data_en,
  output logic       vee_en,
  output logic       bl_en,
  output logic [1:0] pad_drive,
  output logic       busy,
  output logic       done
);
  localparam int DLY_MAX = imax(1, imax(imax(imax(STD_T_VDD, STD_T_DATA), imax(STD_T_VEE, STD_T_BL)),
                                         imax(imax(LEG_T_VDD, LEG_T_DATA), LEG_T_VEE)));
  localparam int CNT_W   = $clog2(DLY_MAX + 1);

  lvl_t             lvl_q;
  prof_e            prof_q;
  logic             active_q, done_q, step_fire, timer_clr, expired;
  logic [1:0]       pad_q;
  logic [CNT_W-1:0] limit;
  rails_t           rails;
  logic             want_on;

  assign want_on = (req_mode == REQ_ON);

  pps_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(timer_clr), .tick(ms_tick),
    .limit(limit), .expired(expired)
  );

  pps_step_ctrl #(
    .CNT_W(CNT_W),
    .STD_T_VDD(STD_T_VDD), .STD_T_DATA(STD_T_DATA), .STD_T_VEE(STD_T_VEE), .STD_T_BL(STD_T_BL),
    .LEG_T_VDD(LEG_T_VDD), .LEG_T_DATA(LEG_T_DATA), .LEG_T_VEE(LEG_T_VEE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .want_on(want_on), .prof_sel(legacy_sel),
    .expired(expired), .lvl_q(lvl_q), .prof_q(prof_q), .active_q(active_q),
    .done_q(done_q), .pad_q(pad_q), .step_fire(step_fire),
    .timer_clr(timer_clr), .limit(limit)
  );

  pps_rail_map u_map (.prof(prof_q), .lvl(lvl_q), .rails(rails));

  assign disp_en   = rails.disp;
  assign vdd_en    = rails.vdd;
  assign data_en   = rails.data;
  assign vee_en    = rails.vee;
  assign bl_en     = rails.bl;
  assign pad_drive = pad_q;
  assign busy      = active_q;
  assign done      = done_q;
endmodule

// File: rtl/pps_checker.sv
module pps_checker
  import pps_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] rails,
  input logic       busy,
  input logic       done,
  input logic [1:0] pad_drive,
  input lvl_t       lvl
);
  // rails = {bl, vee, data, vdd, disp}
  p_rail_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rails[2] || rails[1]) && (!rails[3] || rails[2]) && (!rails[4] || rails[3]));

  p_disp_last_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rails[0]) |-> !rails[1]);

  p_single_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> ((lvl == $past(lvl) + 3'd1) || (lvl + 3'd1 == $past(lvl))));

  p_move_while_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rails) |-> $past(busy));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_ends_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_pad_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pad_drive) |-> $past(done));
endmodule

bind panel_power_seq pps_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rails(rails), .busy(busy), .done(done),
  .pad_drive(pad_drive), .lvl(lvl_q)
);

// File: tb/panel_power_seq_test.sv
module panel_power_seq_test;
  localparam int PERIOD = 10;
  localparam int SV = 6, SD = 3, SE = 0, SB = 2;
  localparam int LV = 3, LD = 7, LE = 1;
  // {legacy, power-down code}
  localparam logic [2:0] VECS [4] = '{3'b0_01, 3'b1_10, 3'b0_11, 3'b1_01};

  logic clk = 1'b0, rst_n = 1'b0, legacy_sel = 1'b0, tick_en = 1'b1;
  logic [1:0] req_mode = 2'b01;
  logic disp_en, vdd_en, data_en, vee_en, bl_en, busy, done;
  logic [1:0] pad_drive;
  int cyc = 0, total = 0, bad = 0;
  int rise_st [5];
  int fall_st [5];
  logic [4:0] prev = '0;
  logic [4:0] en;

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign en = {bl_en, vee_en, data_en, vdd_en, disp_en};

  panel_power_seq #(
    .STD_T_VDD(SV), .STD_T_DATA(SD), .STD_T_VEE(SE), .STD_T_BL(SB),
    .LEG_T_VDD(LV), .LEG_T_DATA(LD), .LEG_T_VEE(LE)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .legacy_sel(legacy_sel),
    .ms_tick(tick_en), .disp_en(disp_en), .vdd_en(vdd_en), .data_en(data_en),
    .vee_en(vee_en), .bl_en(bl_en), .pad_drive(pad_drive), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < 5; i++) begin
      if (en[i] && !prev[i]) rise_st[i] = cyc;
      if (!en[i] && prev[i]) fall_st[i] = cyc;
    end
    prev = en;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_stamps();
    for (int i = 0; i < 5; i++) begin rise_st[i] = -1; fall_st[i] = -1; end
  endtask

  task automatic wait_idle(output int tend);
    int guard = 0;
    while (busy && guard < 4000) begin @(negedge clk); guard++; end
    chk("R11 sequence finished", int'(guard < 4000), 1);
    tend = cyc;
  endtask

  task automatic run(input logic [1:0] mode, output int t0, output int tend);
    clear_stamps();
    @(negedge clk); req_mode = mode;
    @(negedge clk); t0 = cyc;
    chk("R11 busy on accept", int'(busy), 1);
    wait_idle(tend);
    chk("R11 done at last step", int'(done), 1);
  endtask

  task automatic pad_after(input logic [1:0] old_v, input logic [1:0] new_v);
    chk("R7 pad unchanged at completion", int'(pad_drive), int'(old_v));
    @(negedge clk);
    chk("R7 pad after completion", int'(pad_drive), int'(new_v));
    chk("R11 done one cycle", int'(done), 0);
  endtask

  task automatic std_down_checks(input int t0, input int tend);
    chk("R3 bl off first", fall_st[4] - t0, 1);
    chk("R3 vee off", fall_st[3] - fall_st[4], SB + 1);
    chk("R8 data off after zero wait", fall_st[2] - fall_st[3], SE + 1);
    chk("R3 vdd off", fall_st[1] - fall_st[2], SD + 1);
    chk("R3 disp off last", fall_st[0] - fall_st[1], 1);
    chk("R11 busy ends at last change", tend, fall_st[0]);
  endtask

  initial begin
    int t0, tend;
    clear_stamps();
    repeat (2) @(negedge clk);
    chk("R1 enables in reset", int'(en), 0);
    chk("R1 pad in reset", int'(pad_drive), 0);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 done in reset", int'(done), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 4; v++) begin
      legacy_sel = VECS[v][2];
      run(2'b00, t0, tend);
      if (!VECS[v][2]) begin
        chk("R2 disp first", rise_st[0] - t0, 1);
        chk("R2 vdd on", rise_st[1] - rise_st[0], SV + 1);
        chk("R2 data on", rise_st[2] - rise_st[1], SD + 1);
        chk("R8 vee after zero wait", rise_st[3] - rise_st[2], SE + 1);
        chk("R2 bl on", rise_st[4] - rise_st[3], SB + 1);
        chk("R11 busy ends at bl", tend, rise_st[4]);
      end else begin
        chk("R4 vdd on", rise_st[1] - t0, LV + 1);
        chk("R4 data on", rise_st[2] - rise_st[1], LD + 1);
        chk("R4 vee on", rise_st[3] - rise_st[2], LE + 1);
        chk("R4 bl with vee", rise_st[4], rise_st[3]);
        chk("R4 disp stays low", rise_st[0], -1);
      end
      pad_after(2'b00, 2'b11);
      repeat (4) @(negedge clk);
      chk("R6 on held while on starts nothing", int'(busy), 0);
      chk("R6 rails stay on", int'(bl_en), 1);
      run(VECS[v][1:0], t0, tend);
      if (!VECS[v][2]) std_down_checks(t0, tend);
      else begin
        chk("R5 vee off", fall_st[3] - t0, LE + 1);
        chk("R5 bl with vee", fall_st[4], fall_st[3]);
        chk("R5 data off", fall_st[2] - fall_st[3], LD + 1);
        chk("R5 vdd off", fall_st[1] - fall_st[2], LV + 1);
        chk("R5 busy ends at vdd", tend, fall_st[1]);
      end
      pad_after(2'b11, 2'b00);
      chk("R6 all off", int'(en), 0);
    end

    // R9: no ticks, no progress past a non-zero wait
    legacy_sel = 1'b0;
    tick_en = 1'b0;
    clear_stamps();
    @(negedge clk); req_mode = 2'b00;
    repeat (20) @(negedge clk);
    chk("R9 disp on without tick", int'(disp_en), 1);
    chk("R9 vdd held without tick", int'(vdd_en), 0);
    chk("R9 busy held", int'(busy), 1);
    tick_en = 1'b1;
    wait_idle(tend);
    chk("R9 bl on after ticks", int'(bl_en), 1);
    @(negedge clk);

    // R12: legacy_sel changed while on is ignored on power-down
    legacy_sel = 1'b1;
    run(2'b11, t0, tend);
    std_down_checks(t0, tend);
    chk("R12 standard order kept", int'(fall_st[0] > 0), 1);
    @(negedge clk);
    legacy_sel = 1'b0;

    // R10: reverse while waiting for vdd
    clear_stamps();
    @(negedge clk); req_mode = 2'b00;
    @(negedge clk); t0 = cyc;
    repeat (3) @(negedge clk);
    req_mode = 2'b10;
    wait_idle(tend);
    chk("R10 vdd step completed", rise_st[1] - rise_st[0], SV + 1);
    chk("R10 vdd off from reached state", fall_st[1] - rise_st[1], SD + 1);
    chk("R10 disp off after vdd", fall_st[0] - fall_st[1], 1);
    chk("R10 data never on", rise_st[2], -1);
    chk("R10 ends at disp off", tend, fall_st[0]);
    pad_after(2'b00, 2'b00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule